// File: doc/BRIEF.md
# Extended Feature-Control Register Access Unit

This unit owns the register that records which extended processor state components are enabled, and answers the read and write requests a core sends to it. Each request carries the operation (read or write), a register index, a 64-bit value split into two 32-bit halves, and the context it runs in. That context is the current privilege level, the operating-system enable bit, the mask of features the implementation supports, and two virtualization-guest indications. The unit answers in the same cycle. It returns read data, a fault kind or a request to leave the guest. An accepted write lands on the next clock edge, and a one-cycle mode-change pulse follows it so that dependent logic can re-evaluate which state is enabled.

Writes pass through a fixed sequence of checks: operating-system enable, guest exit, privilege, index, then the value. Only the first check that fails is reported. In the value check, bit 0 (base state) must stay set. Bit 2 (upper vector lane) may only be set together with bit 1 (lower vector lane).

Top module: `xcr_access_unit`

## Requirements
- R1: A valid request of either kind with `os_enable` low reports fault code 1 (invalid opcode) ahead of every other check, even when a guest exit would otherwise be raised.
- R2: After reset the register holds 0x1, and a read of index 0 returns the register in `rd_data[31:0]` with `rd_data[63:32]` zero and fault code 0.
- R3: A request whose index is not 0 reports fault code 2 (general protection).
- R4: A write while `guest_a` is high raises `vm_exit`, reports fault code 0 and leaves the register unchanged.
- R5: A write while `guest_b` is high raises `vm_exit` only if `guest_b_icpt` is high; otherwise the write continues through the remaining checks.
- R6: A write at a nonzero privilege level reports fault code 2.
- R7: A write reports fault code 2 if the high half is nonzero, if a low-half bit lies outside `feat_mask`, or if bit 0 is clear.
- R8: A write with bit 2 set and bit 1 clear reports fault code 2.
- R9: Checks apply in the order enable, guest exit, privilege, index, value, and only the first failing one is reported.
- R10: An accepted write changes the register at the next clock edge, and `mode_change` is high for exactly the cycle after that edge.
- R11: A rejected or exiting write, a read, and an idle cycle leave the register unchanged and give no `mode_change` pulse. With no request, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register index |
| wr_hi | input | 32 | High half of the write value |
| wr_lo | input | 32 | Low half of the write value |
| cpl | input | 2 | Current privilege level |
| os_enable | input | 1 | Operating system has enabled the access instructions |
| feat_mask | input | 32 | Features the implementation supports |
| guest_a | input | 1 | Running in a guest that always exits on writes |
| guest_b | input | 1 | Running in a guest that exits on writes when intercepted |
| guest_b_icpt | input | 1 | Write intercept enabled for guest_b |
| rd_data | output | 64 | Read result, zero unless a clean read |
| fault_kind | output | 2 | 0 none, 1 invalid opcode, 2 general protection |
| vm_exit | output | 1 | Request to leave the guest |
| mode_change | output | 1 | One-cycle pulse after the register changes |

## Verification
The bench sets up cases where several checks fail at once, so that an order that was wrong would report general protection where invalid opcode or an exit is due. Guest-b without intercept must fall through to the value checks; a design that always exits would give no fault and never update. The value cases test each rejection on its own: a nonzero high half, a bit outside the mask, bit 0 clear, and upper lane without lower lane. If one of these were missing, the register would take the bad value, and the read that follows would show it. The mode pulse is checked one cycle after each accepted write and is checked to be absent after a rejected one.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_UD   = 2'd1,
      FLT_GP   = 2'd2
   } fault_e;
endpackage

// File: rtl/xcr_gate.sv
module xcr_gate
   import xcr_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter int IDX_W     = 32,
   parameter int CPL_W     = 2,
   parameter int BASE_BIT  = 0,
   parameter int LOWER_BIT = 1,
   parameter int UPPER_BIT = 2,
   parameter bit HAS_UPPER = 1'b1
) (
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [IDX_W-1:0] req_index,
   input  logic [REG_W-1:0] wr_hi,
   input  logic [REG_W-1:0] wr_lo,
   input  logic [CPL_W-1:0] cpl,
   input  logic             os_enable,
   input  logic [REG_W-1:0] feat_mask,
   input  logic             guest_a,
   input  logic             guest_b,
   input  logic             guest_b_icpt,
   output fault_e           fault,
   output logic             exit_req,
   output logic             accept
);
   logic dep_bad;
   logic value_bad;
   logic want_exit;

   generate
      if (HAS_UPPER) begin : g_dep
         assign dep_bad = wr_lo[UPPER_BIT] & ~wr_lo[LOWER_BIT];
      end else begin : g_nodep
         assign dep_bad = 1'b0;
      end
   endgenerate

   assign value_bad = (|wr_hi) | (|(wr_lo & ~feat_mask)) | ~wr_lo[BASE_BIT] | dep_bad;
   assign want_exit = guest_a | (guest_b & guest_b_icpt);

   always_comb begin
      fault    = FLT_NONE;
      exit_req = 1'b0;
      accept   = 1'b0;
      if (req_valid) begin
         if (!os_enable) begin
            fault = FLT_UD;
         end else if (req_write) begin
            if (want_exit)               exit_req = 1'b1;
            else if (cpl != '0)          fault    = FLT_GP;
            else if (req_index != '0)    fault    = FLT_GP;
            else if (value_bad)          fault    = FLT_GP;
            else                         accept   = 1'b1;
         end else if (req_index != '0) begin
            fault = FLT_GP;
         end
      end
   end
endmodule

// File: rtl/xcr_store.sv
module xcr_store #(
   parameter int               REG_W     = 32,
   parameter logic [REG_W-1:0] RESET_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [REG_W-1:0] wval,
   output logic [REG_W-1:0] xcr_q,
   output logic             mode_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xcr_q      <= RESET_VAL;
         mode_pulse <= 1'b0;
      end else begin
         mode_pulse <= accept;
         if (accept) xcr_q <= wval;
      end
   end
endmodule

// File: rtl/xcr_access_unit.sv
module xcr_access_unit
   import xcr_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter int IDX_W     = 32,
   parameter int CPL_W     = 2,
   parameter int BASE_BIT  = 0,
   parameter int LOWER_BIT = 1,
   parameter int UPPER_BIT = 2,
   parameter bit HAS_UPPER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [IDX_W-1:0]   req_index,
   input  logic [REG_W-1:0]   wr_hi,
   input  logic [REG_W-1:0]   wr_lo,
   input  logic [CPL_W-1:0]   cpl,
   input  logic               os_enable,
   input  logic [REG_W-1:0]   feat_mask,
   input  logic               guest_a,
   input  logic               guest_b,
   input  logic               guest_b_icpt,
   output logic [2*REG_W-1:0] rd_data,
   output logic [1:0]         fault_kind,
   output logic               vm_exit,
   output logic               mode_change
);
   localparam int               RD_W      = 2 * REG_W;
   localparam logic [REG_W-1:0] RESET_VAL = REG_W'(1) << BASE_BIT;

   generate
      if (BASE_BIT >= REG_W || LOWER_BIT >= REG_W || UPPER_BIT >= REG_W) begin : g_bad_pos
         $error("feature bit position outside register width");
      end
      if (HAS_UPPER && (LOWER_BIT == UPPER_BIT || LOWER_BIT == BASE_BIT)) begin : g_bad_lane
         $error("lane bits must be distinct");
      end
   endgenerate

   fault_e           fault;
   logic             accept;
   logic [REG_W-1:0] xcr_q;

   xcr_gate #(
      .REG_W(REG_W), .IDX_W(IDX_W), .CPL_W(CPL_W), .BASE_BIT(BASE_BIT),
      .LOWER_BIT(LOWER_BIT), .UPPER_BIT(UPPER_BIT), .HAS_UPPER(HAS_UPPER)
   ) u_gate (
      .req_valid(req_valid), .req_write(req_write), .req_index(req_index),
      .wr_hi(wr_hi), .wr_lo(wr_lo), .cpl(cpl), .os_enable(os_enable),
      .feat_mask(feat_mask), .guest_a(guest_a), .guest_b(guest_b),
      .guest_b_icpt(guest_b_icpt), .fault(fault), .exit_req(vm_exit),
      .accept(accept)
   );

   xcr_store #(.REG_W(REG_W), .RESET_VAL(RESET_VAL)) u_store (
      .clk(clk), .rst_n(rst_n), .accept(accept), .wval(wr_lo),
      .xcr_q(xcr_q), .mode_pulse(mode_change)
   );

   assign fault_kind = fault;
   assign rd_data    = (req_valid && !req_write && fault == FLT_NONE)
                       ? {{(RD_W-REG_W){1'b0}}, xcr_q} : '0;
endmodule

// File: rtl/xcr_access_chk.sv
module xcr_access_chk #(
   parameter int REG_W     = 32,
   parameter int BASE_BIT  = 0,
   parameter int LOWER_BIT = 1,
   parameter int UPPER_BIT = 2,
   parameter bit HAS_UPPER = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_write,
   input logic               os_enable,
   input logic [2*REG_W-1:0] rd_data,
   input logic [1:0]         fault_kind,
   input logic               vm_exit,
   input logic               mode_change,
   input logic [REG_W-1:0]   xcr_q
);
   logic wr_ok;
   assign wr_ok = req_valid && req_write && fault_kind == 2'd0 && !vm_exit;

   // R1
   ud_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !os_enable) |-> (fault_kind == 2'd1 && !vm_exit));
   // R2
   rd_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[2*REG_W-1:REG_W] == '0);
   // R7
   base_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xcr_q[BASE_BIT]);
   // R8
   lane_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(HAS_UPPER && xcr_q[UPPER_BIT] && !xcr_q[LOWER_BIT]));
   // R9
   exit_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vm_exit |-> (fault_kind == 2'd0 && req_write));
   // R10
   pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> mode_change);
   // R11
   no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ok |=> (!mode_change && $stable(xcr_q)));
endmodule

bind xcr_access_unit xcr_access_chk #(
   .REG_W(REG_W), .BASE_BIT(BASE_BIT), .LOWER_BIT(LOWER_BIT),
   .UPPER_BIT(UPPER_BIT), .HAS_UPPER(HAS_UPPER)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .os_enable(os_enable), .rd_data(rd_data), .fault_kind(fault_kind),
   .vm_exit(vm_exit), .mode_change(mode_change), .xcr_q(xcr_q)
);

// File: tb/xcr_access_unit_test.sv
module xcr_access_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0;
   logic [31:0] req_index = 0, wr_hi = 0, wr_lo = 0;
   logic [1:0]  cpl = 0;
   logic        os_enable = 0;
   logic [31:0] feat_mask = 32'h7;
   logic        guest_a = 0, guest_b = 0, guest_b_icpt = 0;
   logic [63:0] rd_data;
   logic [1:0]  fault_kind;
   logic        vm_exit, mode_change;

   always #5 clk = ~clk;

   xcr_access_unit uut (.*);

   typedef struct {
      string       tag;
      logic [63:0] rd;
      logic [1:0]  flt;
      logic        ex;
      logic        md;
   } exp_t;

   exp_t        q[$];
   int          checks = 0, failures = 0;
   logic [31:0] model_reg = 32'h1;
   bit          prev_acc = 0;
   bit          done = 0;

   task automatic drive(string tag, bit v, bit w, logic [31:0] idx, logic [31:0] hi,
                        logic [31:0] lo, logic [1:0] pl, bit en, bit ga, bit gb, bit gbi);
      exp_t e;
      bit   acc;
      @(posedge clk); #1;
      req_valid = v; req_write = w; req_index = idx; wr_hi = hi; wr_lo = lo;
      cpl = pl; os_enable = en; guest_a = ga; guest_b = gb; guest_b_icpt = gbi;
      e.tag = tag; e.rd = 64'h0; e.flt = 2'd0; e.ex = 1'b0; e.md = prev_acc; acc = 0;
      if (v) begin
         if (!en) e.flt = 2'd1;
         else if (w) begin
            if (ga || (gb && gbi)) e.ex = 1'b1;
            else if (pl != 0 || idx != 0) e.flt = 2'd2;
            else if (hi != 0 || (lo & ~feat_mask) != 0 || !lo[0] || (lo[2] && !lo[1]))
               e.flt = 2'd2;
            else acc = 1;
         end else if (idx != 0) e.flt = 2'd2;
         else e.rd = {32'h0, model_reg};
      end
      q.push_back(e);
      if (acc) model_reg = lo;
      prev_acc = acc;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rd_data !== e.rd || fault_kind !== e.flt || vm_exit !== e.ex || mode_change !== e.md) begin
               failures++;
               $display("FAIL %s: got rd=%h flt=%0d exit=%0b mode=%0b, expected rd=%h flt=%0d exit=%0b mode=%0b",
                        e.tag, rd_data, fault_kind, vm_exit, mode_change, e.rd, e.flt, e.ex, e.md);
            end
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      //     tag   v w idx hi lo   cpl en ga gb gbi
      drive("R11", 0,0, 0, 0, 0,     0, 1, 0, 0, 0);
      drive("R2",  1,0, 0, 0, 0,     0, 1, 0, 0, 0);
      drive("R1",  1,0, 0, 0, 0,     0, 0, 0, 0, 0);
      drive("R1",  1,1, 5, 1, 0,     3, 0, 1, 0, 0);
      drive("R3",  1,0, 1, 0, 0,     0, 1, 0, 0, 0);
      drive("R4",  1,1, 0, 0, 3,     0, 1, 1, 0, 0);
      drive("R9",  1,1, 7, 1, 0,     3, 1, 1, 0, 0);
      drive("R5",  1,1, 0, 0, 3,     0, 1, 0, 1, 1);
      drive("R2",  1,0, 0, 0, 0,     0, 1, 0, 0, 0);
      drive("R5",  1,1, 0, 0, 3,     0, 1, 0, 1, 0);
      drive("R10", 1,0, 0, 0, 0,     0, 1, 0, 0, 0);
      drive("R6",  1,1, 0, 0, 7,     2, 1, 0, 0, 0);
      drive("R9",  1,1, 4, 1, 6,     1, 1, 0, 0, 0);
      drive("R3",  1,1, 2, 0, 7,     0, 1, 0, 0, 0);
      drive("R7",  1,1, 0, 1, 7,     0, 1, 0, 0, 0);
      drive("R7",  1,1, 0, 0, 32'hF, 0, 1, 0, 0, 0);
      drive("R7",  1,1, 0, 0, 6,     0, 1, 0, 0, 0);
      drive("R8",  1,1, 0, 0, 5,     0, 1, 0, 0, 0);
      drive("R11", 1,0, 0, 0, 0,     0, 1, 0, 0, 0);
      drive("R10", 1,1, 0, 0, 7,     0, 1, 0, 0, 0);
      drive("R10", 1,1, 0, 0, 1,     0, 1, 0, 0, 0);
      drive("R10", 1,0, 0, 0, 0,     0, 1, 0, 0, 0);
      drive("R11", 0,0, 0, 0, 0,     0, 1, 0, 0, 0);
      drive("R11", 1,0, 0, 0, 0,     0, 1, 0, 0, 0);
      @(posedge clk);
      @(posedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule